// File: doc/BRIEF.md
# Continuous-Phase AFSK Tone Synthesizer

This block turns a serial bit stream into an 8-bit unsigned audio sample stream for 1200 bit/s audio frequency-shift keying with a 1200 Hz mark and a 2200 Hz space tone. The output sample rate is 19200 samples/s. Each pulse on `sample_en` produces one new sample. A 9-bit phase accumulator walks a 512-step sine circle. Only one quarter of the wave is stored, and the other three quarters are rebuilt by mirroring the index and inverting the value.

Data bits arrive on a valid/ready handshake and are NRZI coded. A 0 swaps the tone at the start of its bit period, and a 1 keeps the current tone. Every bit lasts 16 samples. The phase runs on across tone swaps, so the waveform has no jumps.

The block applies back-pressure by default: `bit_ready` is high for only one clock, right after the 16th sample of a bit period. A source keeps `bit_valid` and `bit_data` steady until it sees that pulse. If no bit is offered at the pulse, the current tone continues for another full period and the next chance comes 16 samples later.

Top module: `afsk_tone_gen`

## Requirements
- R1: After reset, `sample_out` is 128, `bit_ready` is 0, the phase is 0 and the mark tone is selected. The first sample produced after reset is therefore 128.
- R2: On a clock with `sample_en` high, `sample_out` takes the sine value S(p) of the current phase p, and p advances by the active increment modulo 512. On a clock with `sample_en` low, `sample_out` and the phase do not change.
- R3: The quarter table is Q[i] = round(127.5 + 127.5·sin(2π·i/512)) for i = 0..127, where a half rounds up. The table runs from 128 to 255. S(p) is built as follows: h = p mod 256; the index is 255−h if h ≥ 128, otherwise h; the value is 255−Q[index] if p ≥ 256, otherwise Q[index].
- R4: The phase increment is floor((512·f + 9600)/19200). This gives 32 for the mark tone and 59 for the space tone.
- R5: `bit_ready` is high for exactly one clock: the clock after the clock whose `sample_en` produced the 16th sample of a bit period. A bit period is 16 consecutive `sample_en` pulses counted from reset.
- R6: A bit is taken only on a clock where `bit_valid` and `bit_ready` are both high. A bit held on `bit_valid` at other times has no effect on the tone.
- R7: A taken bit of value 0 swaps the tone (mark becomes space, space becomes mark). The swap already applies to a sample produced on the same clock. A taken bit of value 1 leaves the tone unchanged.
- R8: If no bit is valid when `bit_ready` pulses, the tone is held and the next `bit_ready` pulse comes 16 samples later.
- R9: The phase is never reset or realigned on a tone swap, so samples continue from the accumulated phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Produce one output sample on this clock |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | The offered data bit (NRZI: 0 swaps the tone) |
| bit_ready | output | 1 | One-clock pulse: the next bit may be taken |
| sample_out | output | 8 | Unsigned audio sample, midscale 128 |

## Verification
A wrong tone state does not change the current sample. It bends the very next sample after a taken bit away from the expected continuous-phase value, and the error then persists in every sample that follows, because the phase carries it forward. A wrong count of samples per bit shows up as a `bit_ready` pulse at the wrong clock, and after that the bits are taken at the wrong moments. The bench compares every sample and the `bit_ready` level on every clock against a model driven only by the port activity. Strobe spacings from back-to-back up to six clocks are used, so a handshake and a sample can also fall on the same clock.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

  localparam int SAMPLE_W = 8;

  typedef enum logic {TONE_MARK = 1'b0, TONE_SPACE = 1'b1} tone_e;

  // mark -> space, anything else -> mark
  function automatic tone_e tone_swap(tone_e t);
    return (t == TONE_MARK) ? TONE_SPACE : TONE_MARK;
  endfunction

  // phase step per sample, rounded by adding half the divisor
  function automatic int tone_step(int circle, int freq_hz, int rate_hz);
    return (circle * freq_hz + rate_hz / 2) / rate_hz;
  endfunction

  // one entry of the stored first quarter of the wave
  function automatic logic [SAMPLE_W-1:0] quarter_sine(int idx, int circle);
    real mid;
    real ang;
    int  v;
    mid = real'((1 << SAMPLE_W) - 1) / 2.0;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(circle);
    v   = int'(mid + mid * $sin(ang));
    if (v > (1 << SAMPLE_W) - 1) v = (1 << SAMPLE_W) - 1;
    if (v < 0) v = 0;
    return v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/afsk_bit_clock.sv
module afsk_bit_clock #(
  parameter int SAMPLES_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic ready
);
  localparam int CW = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (step) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          ready <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: the window lasts one clock and follows a sample strobe
  a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  a_r5_ready_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    step && (cnt != LAST) |=> !ready);

endmodule

// File: rtl/afsk_phase_nco.sv
module afsk_phase_nco
  import afsk_pkg::*;
#(
  parameter int PHASE_W   = 9,
  parameter int MARK_INC  = 32,
  parameter int SPACE_INC = 59
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               flip,
  output logic [PHASE_W-1:0] phase
);
  tone_e              tone;
  tone_e              tone_eff;
  logic [PHASE_W-1:0] inc_eff;

  always_comb begin
    tone_eff = flip ? tone_swap(tone) : tone;
    inc_eff  = (tone_eff == TONE_MARK) ? PHASE_W'(MARK_INC) : PHASE_W'(SPACE_INC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone  <= TONE_MARK;
      phase <= '0;
    end else begin
      tone <= tone_eff;
      if (step) phase <= phase + inc_eff;
    end
  end

  // R7: a flip always moves the tone to the other value
  a_r7_flip_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> tone != $past(tone));
  // R6 / R8: without a flip the tone stays put
  a_r6_tone_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(tone));
  // R2: no strobe, no phase movement
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(phase));

endmodule

// File: rtl/afsk_sine_fold.sv
module afsk_sine_fold
  import afsk_pkg::*;
#(
  parameter int PHASE_W = 9
) (
  input  logic [PHASE_W-1:0]  phase,
  output logic [SAMPLE_W-1:0] value
);
  localparam int QW     = PHASE_W - 2;
  localparam int QN     = 1 << QW;
  localparam int CIRCLE = 1 << PHASE_W;

  logic [SAMPLE_W-1:0] rom [QN];
  logic [QW-1:0]       idx;
  logic [SAMPLE_W-1:0] qv;

  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign rom[g] = quarter_sine(g, CIRCLE);
  end

  always_comb begin
    // second quarter of each half runs the table backwards
    idx   = phase[PHASE_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];
    qv    = rom[idx];
    // second half is the mirror image about midscale
    value = phase[PHASE_W-1] ? ~qv : qv;
  end

endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen
  import afsk_pkg::*;
#(
  parameter int PHASE_W     = 9,
  parameter int SAMPLE_RATE = 19200,
  parameter int BIT_RATE    = 1200,
  parameter int MARK_HZ     = 1200,
  parameter int SPACE_HZ    = 2200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                bit_valid,
  input  logic                bit_data,
  output logic                bit_ready,
  output logic [SAMPLE_W-1:0] sample_out
);
  localparam int CIRCLE    = 1 << PHASE_W;
  localparam int SPB       = SAMPLE_RATE / BIT_RATE;
  localparam int MARK_INC  = tone_step(CIRCLE, MARK_HZ, SAMPLE_RATE);
  localparam int SPACE_INC = tone_step(CIRCLE, SPACE_HZ, SAMPLE_RATE);
  localparam logic [SAMPLE_W-1:0] MIDSCALE = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic               take;
  logic               flip;
  logic [PHASE_W-1:0] phase;
  logic [SAMPLE_W-1:0] sine_val;

  assign take = bit_valid && bit_ready;
  assign flip = take && !bit_data;

  afsk_bit_clock #(.SAMPLES_PER_BIT(SPB)) u_bitclk (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sample_en),
    .ready (bit_ready)
  );

  afsk_phase_nco #(
    .PHASE_W  (PHASE_W),
    .MARK_INC (MARK_INC),
    .SPACE_INC(SPACE_INC)
  ) u_nco (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (sample_en),
    .flip  (flip),
    .phase (phase)
  );

  afsk_sine_fold #(.PHASE_W(PHASE_W)) u_fold (
    .phase (phase),
    .value (sine_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_out <= MIDSCALE;
    else if (sample_en) sample_out <= sine_val;
  end

  // R2: output only moves on a strobe
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(sample_out));
  // R1: the first strobe after reset reads phase 0, i.e. midscale
  a_r1_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && (phase == '0) |=> sample_out == MIDSCALE);

endmodule

// File: tb/afsk_tone_gen_bench.sv
module afsk_tone_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       bit_ready;
  logic [7:0] sample_out;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  afsk_tone_gen u_afsk_tone_gen (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .sample_out(sample_out)
  );

  // reference from R3
  function automatic int q_ref(int i);
    int v;
    v = int'(127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * real'(i) / 512.0));
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic int s_ref(int p);
    int h;
    int ix;
    h  = p % 256;
    ix = (h >= 128) ? 255 - h : h;
    return (p >= 256) ? 255 - q_ref(ix) : q_ref(ix);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // strobe generator
  int sgap = 3;
  bit sen_on = 0;
  int gcnt = 0;
  always @(posedge clk) begin
    #1;
    if (sen_on && gcnt >= sgap) begin
      sample_en = 1'b1;
      gcnt = 0;
    end else begin
      sample_en = 1'b0;
      if (sen_on) gcnt++;
    end
  end

  // scoreboard: driver pushes bits, monitor pops on handshakes
  bit exp_bits[$];
  int mphase = 0;
  int minc = 32;   // R4: mark step 32, space step 59
  int mcnt = 0;
  bit exp_rdy = 0;
  bit pend = 0;
  int exp_sample = 128;
  int last_out = 128;

  always @(negedge clk) begin
    if (!rst_n) begin
      mphase = 0; minc = 32; mcnt = 0; exp_rdy = 0; pend = 0; last_out = 128;
    end else begin
      bit rdy_next;
      check(bit_ready == exp_rdy, "R5/R8 ready timing", bit_ready, exp_rdy);
      if (pend)
        check(sample_out == exp_sample, "R2/R3/R4/R9 sample", sample_out, exp_sample);
      else
        check(sample_out == last_out, "R2 hold without strobe", sample_out, last_out);
      last_out = sample_out;
      rdy_next = 0;
      if (bit_valid && bit_ready) begin
        bit eb;
        if (exp_bits.size() == 0) begin
          check(0, "R6 unexpected take", 1, 0);
        end else begin
          eb = exp_bits.pop_front();
          check(bit_data == eb, "R6 taken bit", bit_data, eb);
        end
        if (!bit_data) minc = (minc == 32) ? 59 : 32;  // R7 swap
      end
      if (sample_en) begin
        exp_sample = s_ref(mphase);
        mphase = (mphase + minc) % 512;
        mcnt++;
        if (mcnt == 16) begin
          mcnt = 0;
          rdy_next = 1;
        end
        pend = 1;
      end else begin
        pend = 0;
      end
      exp_rdy = rdy_next;
    end
  end

  task automatic send_bit(bit b);
    bit hs;
    @(posedge clk); #2;
    bit_valid = 1'b1;
    bit_data = b;
    exp_bits.push_back(b);
    do begin
      @(negedge clk);
      hs = bit_ready;
    end while (!hs);
    @(posedge clk); #2;
    bit_valid = 1'b0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_cycles(3);
    @(negedge clk);
    check(sample_out == 128, "R1 reset sample", sample_out, 128);
    check(bit_ready == 1'b0, "R1 reset ready", bit_ready, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    // R6: a bit offered before any window must wait for bit_ready
    sen_on = 1;
    sgap = 3;
    send_bit(1'b1);
    @(negedge clk);
    check(exp_bits.size() == 0, "R6 first bit taken at window", exp_bits.size(), 0);
    // R7 mixed NRZI pattern
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    // R8 idle: no bit offered for several periods
    wait_cycles(4 * 16 * 3);
    // R2 strobes stopped: output must hold
    sen_on = 0;
    wait_cycles(30);
    sen_on = 1;
    // back-to-back strobes: take and sample on the same clock (R7)
    sgap = 0;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    // slower strobes with pseudo-random data (R9 continuity)
    sgap = 5;
    for (int k = 0; k < 20; k++) send_bit(1'($urandom_range(0, 1)));
    wait_cycles(16 * 6 + 10);
    check(exp_bits.size() == 0, "R6 all bits taken", exp_bits.size(), 0);
    sen_on = 0;
    wait_cycles(5);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule